// File: doc/BRIEF.md
# Software Side-Effect Register Field

This block is one storage field of a control/status register bank. It has a configurable width and reset value. An upstream address decoder raises a per-field access strobe, together with a read/write flag and the write data. From these the field updates its contents. A write can store the data, act bit by bit with write-one or write-zero semantics, or clear or set the whole field. A read can leave the field alone, clear it or set it.

Both the write rule and the read rule are chosen with elaboration parameters. An optional protect input can veto software writes. A parameter selects whether that input is ignored, active high or active low. The field outputs its stored value, a read-access pulse and a modify pulse. It also outputs the AND, OR and XOR reductions of its contents, which downstream logic uses as summary flags.

Bus protocol, address decode and the readback multiplexer belong to the surrounding bank and are not part of this block.

Top module: `sw_field`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the field loads `RST_VAL` at that edge. Reset is synchronous and active high.
- R2: With `WR_MODE` = `WM_PLAIN`, an accepted write stores `wdata` unchanged.
- R3: With `WM_ONE_SET`, `WM_ONE_CLR` or `WM_ONE_TGL`, each `wdata` bit equal to 1 sets, clears or toggles the matching field bit. Field bits whose `wdata` bit is 0 are kept.
- R4: With `WM_ZERO_SET`, `WM_ZERO_CLR` or `WM_ZERO_TGL`, each `wdata` bit equal to 0 sets, clears or toggles the matching field bit. Field bits whose `wdata` bit is 1 are kept.
- R5: With `WM_ANY_CLR`, an accepted write makes the field all zeros whatever the data. With `WM_ANY_SET`, an accepted write makes it all ones.
- R6: With `RD_MODE` = `RM_CLR`, a read makes the field all zeros at the following edge. With `RM_SET`, a read makes it all ones. With `RM_NONE`, a read leaves it unchanged.
- R7: With `PROT` = `WP_HIGH`, a write is accepted only while `wr_en` is 1. With `WP_LOW`, a write is accepted only while `wr_en` is 0. With `WP_NONE`, `wr_en` is ignored. A blocked write leaves the field unchanged and raises no modify pulse.
- R8: `acc_pulse` is 1 exactly in the cycles where `acc_stb` = 1 and `is_write` = 0. This is the cycle in which the field is sampled for the read.
- R9: `mod_pulse` is 1 in a cycle with an accepted write, or with a read when `RD_MODE` is not `RM_NONE`. Otherwise it is 0. `value` shows the new contents one cycle after the pulse and does not change in cycles without the pulse.
- R10: `red_and`, `red_or` and `red_xor` always equal the AND, OR and XOR of all bits of `value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | Decoded access strobe for this field |
| is_write | input | 1 | 1 = write access, 0 = read access |
| wdata | input | W | Write data for the field |
| wr_en | input | 1 | Hardware write-protect qualifier (polarity set by PROT) |
| value | output | W | Stored field contents |
| acc_pulse | output | 1 | Read-sample pulse |
| mod_pulse | output | 1 | Software-modify pulse |
| red_and | output | 1 | AND of all field bits |
| red_or | output | 1 | OR of all field bits |
| red_xor | output | 1 | XOR of all field bits |

## Verification
The assertions assume that the inputs are stable and known at every rising edge. They also assume that `is_write` and `wdata` only matter while `acc_stb` is 1, so strobe-low cycles must hold the field. The stimulus changes every input only on the falling edge. It sweeps every 4-bit data value with the protect input at both levels, and puts a read and an idle cycle after each write. Thirteen instances cover every write mode, both read side effects and both protect polarities.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [3:0] {
        WM_PLAIN, WM_ONE_SET, WM_ONE_CLR, WM_ONE_TGL,
        WM_ZERO_SET, WM_ZERO_CLR, WM_ZERO_TGL, WM_ANY_CLR, WM_ANY_SET
    } wr_mode_e;

    typedef enum logic [1:0] { RM_NONE, RM_CLR, RM_SET } rd_mode_e;

    typedef enum logic [1:0] { WP_NONE, WP_HIGH, WP_LOW } wprot_e;
endpackage

// File: rtl/sf_wr_next.sv
module sf_wr_next #(
    parameter int               W    = 8,
    parameter sf_pkg::wr_mode_e MODE = sf_pkg::WM_PLAIN
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    generate
        case (MODE)
            sf_pkg::WM_ONE_SET:  begin : g_os assign nxt = cur | wdata;            end
            sf_pkg::WM_ONE_CLR:  begin : g_oc assign nxt = cur & ~wdata;           end
            sf_pkg::WM_ONE_TGL:  begin : g_ot assign nxt = cur ^ wdata;            end
            sf_pkg::WM_ZERO_SET: begin : g_zs assign nxt = cur | ~wdata;           end
            sf_pkg::WM_ZERO_CLR: begin : g_zc assign nxt = cur & wdata;            end
            sf_pkg::WM_ZERO_TGL: begin : g_zt assign nxt = cur ^ ~wdata;           end
            sf_pkg::WM_ANY_CLR:  begin : g_ac assign nxt = '0;                     end
            sf_pkg::WM_ANY_SET:  begin : g_as assign nxt = ONES;                   end
            default:             begin : g_pl assign nxt = wdata;                  end
        endcase
    endgenerate

    logic unused_ok;
    assign unused_ok = ^{cur, wdata};
endmodule

// File: rtl/sf_rd_next.sv
module sf_rd_next #(
    parameter int               W    = 8,
    parameter sf_pkg::rd_mode_e MODE = sf_pkg::RM_NONE
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         side_eff
);
    generate
        if (MODE == sf_pkg::RM_CLR) begin : g_clr
            assign nxt      = '0;
            assign side_eff = 1'b1;
        end else if (MODE == sf_pkg::RM_SET) begin : g_set
            assign nxt      = {W{1'b1}};
            assign side_eff = 1'b1;
        end else begin : g_none
            assign nxt      = cur;
            assign side_eff = 1'b0;
        end
    endgenerate

    logic unused_ok;
    assign unused_ok = ^cur;
endmodule

// File: rtl/sf_reduce.sv
module sf_reduce #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic         all_one,
    output logic         any_one,
    output logic         parity
);
    always_comb begin
        all_one = 1'b1;
        any_one = 1'b0;
        parity  = 1'b0;
        for (int i = 0; i < W; i++) begin
            all_one = all_one & val[i];
            any_one = any_one | val[i];
            parity  = parity ^ val[i];
        end
    end
endmodule

// File: rtl/sw_field.sv
module sw_field #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0,
    parameter sf_pkg::wr_mode_e WR_MODE = sf_pkg::WM_PLAIN,
    parameter sf_pkg::rd_mode_e RD_MODE = sf_pkg::RM_NONE,
    parameter sf_pkg::wprot_e   PROT    = sf_pkg::WP_NONE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_stb,
    input  logic         is_write,
    input  logic [W-1:0] wdata,
    input  logic         wr_en,
    output logic [W-1:0] value,
    output logic         acc_pulse,
    output logic         mod_pulse,
    output logic         red_and,
    output logic         red_or,
    output logic         red_xor
);
    typedef struct packed {
        logic [W-1:0] val;
    } fld_t;

    fld_t         st_d, st_q;
    logic [W-1:0] wr_val, rd_val;
    logic         rd_eff;
    logic         wr_ok;
    logic         do_wr, do_rd;

    sf_wr_next #(.W(W), .MODE(WR_MODE)) u_wr (
        .cur(st_q.val), .wdata(wdata), .nxt(wr_val)
    );

    sf_rd_next #(.W(W), .MODE(RD_MODE)) u_rd (
        .cur(st_q.val), .nxt(rd_val), .side_eff(rd_eff)
    );

    generate
        if (PROT == sf_pkg::WP_HIGH) begin : g_ph
            assign wr_ok = wr_en;
        end else if (PROT == sf_pkg::WP_LOW) begin : g_pl
            assign wr_ok = ~wr_en;
        end else begin : g_pn
            logic unused_en;
            assign unused_en = wr_en;
            assign wr_ok     = 1'b1;
        end
    endgenerate

    always_comb begin
        do_wr     = acc_stb & is_write & wr_ok;
        do_rd     = acc_stb & ~is_write;
        st_d      = st_q;
        if (do_wr) begin
            st_d.val = wr_val;
        end else if (do_rd && rd_eff) begin
            st_d.val = rd_val;
        end
        acc_pulse = do_rd;
        mod_pulse = do_wr | (do_rd & rd_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.val <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;

    sf_reduce #(.W(W)) u_red (
        .val(st_q.val), .all_one(red_and), .any_one(red_or), .parity(red_xor)
    );
endmodule

// File: rtl/sw_field_chk.sv
module sw_field_chk #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0,
    parameter sf_pkg::wr_mode_e WR_MODE = sf_pkg::WM_PLAIN,
    parameter sf_pkg::rd_mode_e RD_MODE = sf_pkg::RM_NONE,
    parameter sf_pkg::wprot_e   PROT    = sf_pkg::WP_NONE
) (
    input logic         clk,
    input logic         rst,
    input logic         acc_stb,
    input logic         is_write,
    input logic [W-1:0] wdata,
    input logic         wr_en,
    input logic [W-1:0] value,
    input logic         acc_pulse,
    input logic         mod_pulse,
    input logic         red_and,
    input logic         red_or,
    input logic         red_xor
);
    logic blocked;
    assign blocked = (PROT == sf_pkg::WP_HIGH) ? ~wr_en :
                     (PROT == sf_pkg::WP_LOW)  ?  wr_en : 1'b0;

    logic wr_go;
    assign wr_go = acc_stb & is_write & ~blocked;

    logic unused_ok;
    assign unused_ok = ^wdata;

    AST_RESET_LOAD: assert property (@(posedge clk) rst |=> value == RST_VAL); // R1

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && is_write && blocked) |-> !mod_pulse); // R7

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && is_write && blocked) |=> $stable(value)); // R7

    AST_ACC_IS_READ: assert property (@(posedge clk) disable iff (rst)
        acc_pulse |-> (acc_stb && !is_write)); // R8

    AST_READ_GIVES_ACC: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && !is_write) |-> acc_pulse); // R8

    AST_MOD_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        mod_pulse |-> acc_stb); // R9

    AST_HOLD_NO_MOD: assert property (@(posedge clk) disable iff (rst)
        !mod_pulse |=> $stable(value)); // R9

    AST_WRITE_MODS: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> mod_pulse); // R9

    AST_RED_OR: assert property (@(posedge clk) disable iff (rst)
        red_or == (value != '0)); // R10

    AST_RED_AND: assert property (@(posedge clk) disable iff (rst)
        red_and == (value == {W{1'b1}})); // R10

    AST_RED_XOR: assert property (@(posedge clk) disable iff (rst)
        red_xor == ($countones(value) % 2 == 1)); // R10

    generate
        if (RD_MODE == sf_pkg::RM_CLR) begin : g_rc
            AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (acc_stb && !is_write) |=> value == '0); // R6
        end
        if (RD_MODE == sf_pkg::RM_SET) begin : g_rs
            AST_READ_SETS: assert property (@(posedge clk) disable iff (rst)
                (acc_stb && !is_write) |=> value == {W{1'b1}}); // R6
        end
        if (WR_MODE == sf_pkg::WM_ANY_CLR) begin : g_ac
            AST_ANY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
                wr_go |=> value == '0); // R5
        end
        if (WR_MODE == sf_pkg::WM_ANY_SET) begin : g_as
            AST_ANY_WRITE_SETS: assert property (@(posedge clk) disable iff (rst)
                wr_go |=> value == {W{1'b1}}); // R5
        end
    endgenerate
endmodule

bind sw_field sw_field_chk #(
    .W(W), .RST_VAL(RST_VAL), .WR_MODE(WR_MODE), .RD_MODE(RD_MODE), .PROT(PROT)
) u_chk (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .is_write(is_write),
    .wdata(wdata), .wr_en(wr_en), .value(value), .acc_pulse(acc_pulse),
    .mod_pulse(mod_pulse), .red_and(red_and), .red_or(red_or), .red_xor(red_xor)
);

// File: tb/tb_sw_field.sv
`timescale 1ns/1ps
module tb_sw_field;
    import sf_pkg::*;

    localparam int W  = 4;
    localparam int N  = 13;
    localparam logic [W-1:0] RV = 4'hA;

    function automatic wr_mode_e wm_of(int i);
        return (i < 9) ? wr_mode_e'(i[3:0]) : WM_PLAIN;
    endfunction
    function automatic rd_mode_e rm_of(int i);
        return (i == 9) ? RM_CLR : (i == 10) ? RM_SET : RM_NONE;
    endfunction
    function automatic wprot_e pm_of(int i);
        return (i == 11) ? WP_HIGH : (i == 12) ? WP_LOW : WP_NONE;
    endfunction

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_stb = 1'b0;
    logic         is_write = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         wr_en = 1'b0;

    logic [W-1:0] v_o [N];
    logic         a_o [N];
    logic         m_o [N];
    logic         ra_o [N];
    logic         ro_o [N];
    logic         rx_o [N];

    always #2 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_inst
        sw_field #(
            .W(W), .RST_VAL(RV), .WR_MODE(wm_of(g)), .RD_MODE(rm_of(g)), .PROT(pm_of(g))
        ) dut (
            .clk(clk), .rst(rst), .acc_stb(acc_stb), .is_write(is_write),
            .wdata(wdata), .wr_en(wr_en), .value(v_o[g]), .acc_pulse(a_o[g]),
            .mod_pulse(m_o[g]), .red_and(ra_o[g]), .red_or(ro_o[g]), .red_xor(rx_o[g])
        );
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] model [N];

    task automatic chk(string req, int idx, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst=%0d actual=%0h expected=%0h", req, idx, act, exp);
        end
    endtask

    function automatic string req_of(int i);
        if (i == 0)  return "R2";
        if (i <= 3)  return "R3";
        if (i <= 6)  return "R4";
        if (i <= 8)  return "R5";
        if (i <= 10) return "R6";
        return "R7";
    endfunction

    function automatic bit accepted(int i, bit en);
        case (pm_of(i))
            WP_HIGH: return en;
            WP_LOW:  return !en;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [W-1:0] wr_model(int i, logic [W-1:0] c, logic [W-1:0] d);
        case (wm_of(i))
            WM_ONE_SET:  return c | d;
            WM_ONE_CLR:  return c & ~d;
            WM_ONE_TGL:  return c ^ d;
            WM_ZERO_SET: return c | ~d;
            WM_ZERO_CLR: return c & d;
            WM_ZERO_TGL: return c ^ ~d;
            WM_ANY_CLR:  return 4'h0;
            WM_ANY_SET:  return 4'hF;
            default:     return d;
        endcase
    endfunction

    task automatic step(bit stb, bit wr, logic [W-1:0] d, bit en);
        @(negedge clk);
        acc_stb = stb; is_write = wr; wdata = d; wr_en = en;
        #1;
        for (int i = 0; i < N; i++) begin
            bit exp_mod;
            logic [W-1:0] nx;
            nx = model[i];
            exp_mod = 1'b0;
            if (stb && wr && accepted(i, en)) begin
                nx = wr_model(i, model[i], d);
                exp_mod = 1'b1;
            end else if (stb && !wr && rm_of(i) != RM_NONE) begin
                nx = (rm_of(i) == RM_CLR) ? 4'h0 : 4'hF;
                exp_mod = 1'b1;
            end
            chk("R8 acc_pulse", i, a_o[i], stb && !wr);
            chk("R9 mod_pulse", i, m_o[i], exp_mod);
            model[i] = nx;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk(req_of(i), i, v_o[i], model[i]);
            chk("R10 and", i, ra_o[i], model[i] == 4'hF);
            chk("R10 or",  i, ro_o[i], model[i] != 4'h0);
            chk("R10 xor", i, rx_o[i], ^model[i]);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            model[i] = RV;
            chk("R1 reset", i, v_o[i], RV);
        end
        @(negedge clk);
        rst = 1'b0;
        // sweep data, protect level, each write followed by read and idle
        for (int en = 0; en < 2; en++) begin
            for (int d = 0; d < 16; d++) begin
                step(1'b1, 1'b1, d[W-1:0], en[0]);
                step(1'b1, 1'b0, ~d[W-1:0], en[0]);
                step(1'b0, 1'b1, d[W-1:0], ~en[0]);
            end
        end
        // back-to-back writes with toggling protect
        for (int d = 0; d < 16; d++) begin
            step(1'b1, 1'b1, d[W-1:0], d[0]);
        end
        // reset mid-run returns all fields to reset value (R1)
        @(negedge clk);
        acc_stb = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            model[i] = RV;
            chk("R1 reset mid-run", i, v_o[i], RV);
        end
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 4'h0, 1'b0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule